// File: doc/BRIEF.md
# Dual-Bank Arbitrated SRAM

This block is an on-chip memory built from two single-port SRAM banks that two bus masters share. Each bank has its own round-robin arbiter. When the masters address different banks, both are served in the same cycle. A master waits only when both masters want the same bank. The memory is byte-addressable. Each master can read or write a byte, a half-word or a word. A static endianness input selects which byte lanes a sub-word access uses.

Each master port follows valid/ready rules. The master raises `mX_req` and drives the address, write data, write enable and size. The access is accepted on a rising clock edge where `mX_req` and `mX_rdy` are both high. While `mX_rdy` is low, the master must hold `mX_req` and all request fields stable. `mX_rdy` is computed combinationally from the current requests. It is never high unless `mX_req` is high. Read data has no back-pressure: the master must take `mX_rdata` in the cycle that `mX_rvalid` is high. The `big_endian` pin is a plain control input and is meant to stay static while traffic is in flight.

Top module: `dual_bank_sram`

## Requirements
- R1: Address bit log2(BANK_BYTES) selects the bank (0 or 1). The bits below it are the offset inside the bank, and the two banks hold separate contents.
- R2: When both masters request and their addresses select different banks, both `m0_rdy` and `m1_rdy` are high in that cycle, so N accesses per master complete in N cycles.
- R3: When both masters request the same bank, exactly one `rdy` is high. While both keep requesting, the grant alternates every cycle. The loser's `rdy` stays low, and its access has no effect until it is granted.
- R4: An accepted read raises that master's `rvalid` for exactly one cycle, in the cycle after acceptance, with the data. Writes and idle cycles leave `rvalid` low.
- R5: Size code 0 is a byte. A byte write changes only the one addressed byte, and the other three bytes of the word keep their values.
- R6: Size code 1 is a half-word. Address bit 0 is ignored, so the access is aligned to the half-word at address bit 1.
- R7: Size codes 2 and 3 are a word. Address bits 1:0 are ignored.
- R8: With `big_endian`=0, byte offset k of a word uses data bits 8k+7:8k, and a sub-word value has its least significant byte at the lower address. With `big_endian`=1, byte offset k uses bits 31-8k:24-8k, and the most significant byte sits at the lower address.
- R9: Write data for a byte or half-word is taken from `wdata[7:0]` or `wdata[15:0]`. Read data for a byte or half-word is returned right-justified in `rdata` and zero-extended.
- R10: During and after reset, both `rvalid` outputs are low. With no request, both `rdy` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Lane order: 0 little-endian, 1 big-endian |
| m0_req | input | 1 | Master 0 request valid |
| m0_rdy | output | 1 | Master 0 request accepted this cycle |
| m0_addr | input | log2(BANK_BYTES)+1 | Master 0 byte address |
| m0_we | input | 1 | Master 0 write enable |
| m0_size | input | 2 | Master 0 size code (0 byte, 1 half, 2/3 word) |
| m0_wdata | input | 32 | Master 0 write data |
| m0_rvalid | output | 1 | Master 0 read data valid |
| m0_rdata | output | 32 | Master 0 read data |
| m1_req | input | 1 | Master 1 request valid |
| m1_rdy | output | 1 | Master 1 request accepted this cycle |
| m1_addr | input | log2(BANK_BYTES)+1 | Master 1 byte address |
| m1_we | input | 1 | Master 1 write enable |
| m1_size | input | 2 | Master 1 size code |
| m1_wdata | input | 32 | Master 1 write data |
| m1_rvalid | output | 1 | Master 1 read data valid |
| m1_rdata | output | 32 | Master 1 read data |

## Verification
A table of single-master accesses checks lane placement against a byte-array model:
- It mixes sizes, misaligned addresses and both endianness settings.
- Values written in one mode are read back in the other, so the bench can tell a lane-mapping fault apart from an alignment fault.

Three directed patterns then exercise the parallel function:
- Both masters stream to different banks. Any lost cycle shows as a throughput shortfall.
- Both masters hammer one bank. This separates correct alternation from starvation or double grants.
- Both masters issue simultaneous reads to different banks. This shows that the return path steers each bank's data to the right master.

// File: rtl/dbsram_pkg.sv
package dbsram_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int MASTERS = 2;
  localparam int BANKS   = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/dbsram_lane_fmt.sv
// Per-master decode: bank, word index, lane strobes and placed write data.
module dbsram_lane_fmt
  import dbsram_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic [OFF_W:0]         addr,
  input  logic [1:0]             size,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   big_endian,
  output logic                   bank_sel,
  output logic [OFF_W-3:0]       word_idx,
  output logic [LANES-1:0]       strb,
  output logic [1:0]             lo_lane,
  output logic [DATA_W-1:0]      wdata_lane
);
  logic [1:0]       off;
  logic [LANES-1:0] mask;

  assign off      = addr[1:0];
  assign bank_sel = addr[OFF_W];
  assign word_idx = addr[OFF_W-1:2];

  // lo_lane: lane holding the least significant byte of the element
  always_comb begin
    case (xfer_size_e'(size))
      SZ_BYTE: begin
        mask    = 4'b0001;
        lo_lane = big_endian ? 2'd3 - off : off;
      end
      SZ_HALF: begin
        mask    = 4'b0011;
        lo_lane = (off[1] ^ big_endian) ? 2'd2 : 2'd0;
      end
      default: begin
        mask    = 4'b1111;
        lo_lane = 2'd0;
      end
    endcase
  end

  assign strb       = mask << lo_lane;
  assign wdata_lane = wdata << {lo_lane, 3'b000};
endmodule

// File: rtl/dbsram_rr_arb.sv
// Two-way round-robin arbiter for one bank.
module dbsram_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] want,
  output logic [1:0] gnt
);
  logic last_q;  // 1: master 1 granted most recently

  always_comb begin
    if (want == 2'b11) gnt = last_q ? 2'b01 : 2'b10;
    else               gnt = want;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= 1'b1;
    else if (|gnt)   last_q <= gnt[1];
  end

  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_needs_want_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~want) == 2'b00);
  assert_no_idle_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|want) |-> (|gnt));
  assert_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (want == 2'b11 && $past(want) == 2'b11) |-> (gnt != $past(gnt)));
endmodule

// File: rtl/dbsram_bank_mem.sv
// One single-port bank with byte-lane write strobes and registered read.
module dbsram_bank_mem
  import dbsram_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [LANES-1:0]      strb,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);
  logic [LANES-1:0][7:0] mem [WORDS];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (en && we && strb[l]) mem[idx][l] <= wdata[8*l +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) rdata <= mem[idx];
  end
endmodule

// File: rtl/dual_bank_sram.sv
module dual_bank_sram
  import dbsram_pkg::*;
#(
  parameter int BANK_BYTES = 1024,
  localparam int OFF_W = $clog2(BANK_BYTES),
  localparam int AW    = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              m0_req,
  output logic              m0_rdy,
  input  logic [AW-1:0]     m0_addr,
  input  logic              m0_we,
  input  logic [1:0]        m0_size,
  input  logic [31:0]       m0_wdata,
  output logic              m0_rvalid,
  output logic [31:0]       m0_rdata,
  input  logic              m1_req,
  output logic              m1_rdy,
  input  logic [AW-1:0]     m1_addr,
  input  logic              m1_we,
  input  logic [1:0]        m1_size,
  input  logic [31:0]       m1_wdata,
  output logic              m1_rvalid,
  output logic [31:0]       m1_rdata
);
  localparam int IDX_W = OFF_W - 2;
  localparam int WORDS = BANK_BYTES / LANES;

  logic              req      [MASTERS];
  logic              rdy      [MASTERS];
  logic [AW-1:0]     addr     [MASTERS];
  logic              we       [MASTERS];
  logic [1:0]        size     [MASTERS];
  logic [DATA_W-1:0] wdata    [MASTERS];
  logic              bsel     [MASTERS];
  logic [IDX_W-1:0]  widx     [MASTERS];
  logic [LANES-1:0]  strb     [MASTERS];
  logic [1:0]        lo       [MASTERS];
  logic [DATA_W-1:0] wlane    [MASTERS];
  logic              rv_q     [MASTERS];
  logic              rbank_q  [MASTERS];
  logic [1:0]        rlo_q    [MASTERS];
  logic [1:0]        rsize_q  [MASTERS];
  logic [DATA_W-1:0] rdat     [MASTERS];
  logic [1:0]        gnt_b    [BANKS];
  logic [DATA_W-1:0] brd      [BANKS];

  assign req   = '{m0_req, m1_req};
  assign addr  = '{m0_addr, m1_addr};
  assign we    = '{m0_we, m1_we};
  assign size  = '{m0_size, m1_size};
  assign wdata = '{m0_wdata, m1_wdata};
  assign m0_rdy = rdy[0];
  assign m1_rdy = rdy[1];
  assign m0_rvalid = rv_q[0];
  assign m1_rvalid = rv_q[1];
  assign m0_rdata  = rdat[0];
  assign m1_rdata  = rdat[1];

  for (genvar m = 0; m < MASTERS; m++) begin : g_port
    logic [DATA_W-1:0] raw, shifted;

    dbsram_lane_fmt #(.OFF_W(OFF_W)) u_fmt (
      .addr(addr[m]), .size(size[m]), .wdata(wdata[m]), .big_endian(big_endian),
      .bank_sel(bsel[m]), .word_idx(widx[m]), .strb(strb[m]),
      .lo_lane(lo[m]), .wdata_lane(wlane[m])
    );

    assign rdy[m] = gnt_b[bsel[m]][m];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rv_q[m]    <= 1'b0;
        rbank_q[m] <= 1'b0;
        rlo_q[m]   <= 2'd0;
        rsize_q[m] <= 2'd0;
      end else begin
        rv_q[m] <= req[m] && rdy[m] && !we[m];
        if (req[m] && rdy[m] && !we[m]) begin
          rbank_q[m] <= bsel[m];
          rlo_q[m]   <= lo[m];
          rsize_q[m] <= size[m];
        end
      end
    end

    assign raw     = brd[rbank_q[m]];
    assign shifted = raw >> {rlo_q[m], 3'b000};
    always_comb begin
      case (xfer_size_e'(rsize_q[m]))
        SZ_BYTE: rdat[m] = {24'h0, shifted[7:0]};
        SZ_HALF: rdat[m] = {16'h0, shifted[15:0]};
        default: rdat[m] = shifted;
      endcase
    end

    assert_read_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req[m] && rdy[m] && !we[m]) |=> rv_q[m]);
    assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(req[m] && rdy[m] && !we[m]) |=> !rv_q[m]);
    assert_rdy_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rdy[m] |-> req[m]);
    assert_strobe_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req[m] |-> ($countones(strb[m]) ==
                  ((size[m] == 2'd0) ? 1 : (size[m] == 2'd1) ? 2 : 4)));
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [1:0] want;
    logic       sel;

    assign want = {req[1] && (bsel[1] == 1'(b)), req[0] && (bsel[0] == 1'(b))};
    assign sel  = gnt_b[b][1];

    dbsram_rr_arb u_arb (.clk(clk), .rst_n(rst_n), .want(want), .gnt(gnt_b[b]));

    dbsram_bank_mem #(.WORDS(WORDS), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .en(|gnt_b[b]), .we(we[sel]), .idx(widx[sel]),
      .strb(strb[sel]), .wdata(wlane[sel]), .rdata(brd[b])
    );
  end

  assert_parallel_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req[0] && req[1] && bsel[0] != bsel[1]) |-> (rdy[0] && rdy[1]));
  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req[0] && req[1] && bsel[0] == bsel[1]) |-> (rdy[0] != rdy[1]));
endmodule

// File: tb/tb_dual_bank_sram.sv
module tb_dual_bank_sram;
  localparam int BANK_BYTES = 1024;
  localparam int OFF_W = $clog2(BANK_BYTES);
  localparam int AW = OFF_W + 1;
  localparam int NVEC = 20;

  // {master, we, size[1:0], big_endian, addr[15:0], wdata[31:0]}
  localparam logic [52:0] VEC [NVEC] = '{
    {1'b0,1'b1,2'd2,1'b0,16'h0000,32'h11223344},
    {1'b0,1'b0,2'd2,1'b0,16'h0000,32'h0},
    {1'b1,1'b0,2'd0,1'b0,16'h0001,32'h0},
    {1'b1,1'b0,2'd1,1'b0,16'h0002,32'h0},
    {1'b0,1'b1,2'd0,1'b0,16'h0002,32'hFFFFFFAA},
    {1'b1,1'b0,2'd2,1'b0,16'h0000,32'h0},
    {1'b1,1'b1,2'd2,1'b0,16'h0404,32'hCAFEBABE},
    {1'b0,1'b1,2'd3,1'b0,16'h0004,32'h0BADF00D},
    {1'b0,1'b1,2'd1,1'b0,16'h0007,32'h1234BEEF},
    {1'b1,1'b0,2'd2,1'b0,16'h0005,32'h0},
    {1'b0,1'b0,2'd2,1'b0,16'h0404,32'h0},
    {1'b0,1'b1,2'd2,1'b1,16'h0010,32'h01020304},
    {1'b0,1'b0,2'd0,1'b1,16'h0010,32'h0},
    {1'b1,1'b0,2'd1,1'b1,16'h0012,32'h0},
    {1'b1,1'b1,2'd0,1'b1,16'h0011,32'h000000FF},
    {1'b0,1'b0,2'd2,1'b1,16'h0010,32'h0},
    {1'b0,1'b0,2'd0,1'b0,16'h0010,32'h0},
    {1'b1,1'b1,2'd1,1'b1,16'h0408,32'h0000ABCD},
    {1'b1,1'b0,2'd0,1'b1,16'h0409,32'h0},
    {1'b0,1'b0,2'd1,1'b0,16'h040A,32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b0;
  logic          req   [2] = '{1'b0, 1'b0};
  logic [AW-1:0] addr  [2] = '{'0, '0};
  logic          we    [2] = '{1'b0, 1'b0};
  logic [1:0]    size  [2] = '{2'd0, 2'd0};
  logic [31:0]   wdata [2] = '{32'h0, 32'h0};
  logic          rdy   [2];
  logic          rvalid[2];
  logic [31:0]   rdata [2];
  logic [7:0]    model [2*BANK_BYTES];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_bank_sram #(.BANK_BYTES(BANK_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .m0_req(req[0]), .m0_rdy(rdy[0]), .m0_addr(addr[0]), .m0_we(we[0]),
    .m0_size(size[0]), .m0_wdata(wdata[0]), .m0_rvalid(rvalid[0]), .m0_rdata(rdata[0]),
    .m1_req(req[1]), .m1_rdy(rdy[1]), .m1_addr(addr[1]), .m1_we(we[1]),
    .m1_size(size[1]), .m1_wdata(wdata[1]), .m1_rvalid(rvalid[1]), .m1_rdata(rdata[1])
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // Storage slot of a byte address under a given lane order (R1, R8).
  function automatic int slot(input logic [AW-1:0] a, input bit be);
    int k = int'(a[1:0]);
    int lane = be ? 3 - k : k;
    return int'(a[OFF_W]) * BANK_BYTES + int'(a[OFF_W-1:2]) * 4 + lane;
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [1:0] sz,
                             input logic [31:0] d, input bit be);
    int n = nbytes(sz);
    logic [AW-1:0] base = a & ~(AW'(n - 1));
    for (int k = 0; k < n; k++) begin
      int s = be ? n - 1 - k : k;
      model[slot(base + AW'(k), be)] = d[8*s +: 8];
    end
  endtask

  function automatic logic [31:0] model_read(input logic [AW-1:0] a,
                                             input logic [1:0] sz, input bit be);
    int n = nbytes(sz);
    logic [AW-1:0] base = a & ~(AW'(n - 1));
    logic [31:0] v = 32'h0;
    for (int k = 0; k < n; k++) begin
      int s = be ? n - 1 - k : k;
      v[8*s +: 8] = model[slot(base + AW'(k), be)];
    end
    return v;
  endfunction

  task automatic set_port(input int m, input bit w, input logic [1:0] sz,
                          input logic [AW-1:0] a, input logic [31:0] d);
    req[m] = 1'b1; we[m] = w; size[m] = sz; addr[m] = a; wdata[m] = d;
  endtask

  // One access on one master; rdata checked in the cycle after acceptance.
  task automatic single(input int m, input bit w, input logic [1:0] sz,
                        input logic [AW-1:0] a, input logic [31:0] d, input bit be,
                        input string rq);
    logic [31:0] exp;
    int guard = 0;
    @(negedge clk);
    big_endian = be;
    set_port(m, w, sz, a, d);
    #1;
    while (!rdy[m] && guard < 20) begin
      @(negedge clk); #1; guard++;
    end
    exp = model_read(a, sz, be);
    @(posedge clk);
    @(negedge clk);
    req[m] = 1'b0;
    if (w) begin
      model_write(a, sz, d, be);
      check(rvalid[m] == 1'b0, "R4 write gives no rvalid", 32'(rvalid[m]), 32'h0);
    end else begin
      check(rvalid[m] == 1'b1, "R4 read rvalid", 32'(rvalid[m]), 32'h1);
      check(rdata[m] === exp, rq, rdata[m], exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(rvalid[0] == 1'b0 && rvalid[1] == 1'b0, "R10 rvalid low in reset",
          {rvalid[1], rvalid[0]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(rdy[0] == 1'b0 && rdy[1] == 1'b0, "R10 rdy low without req",
          {rdy[1], rdy[0]}, 32'h0);
    check(rvalid[0] == 1'b0 && rvalid[1] == 1'b0, "R10 rvalid low after reset",
          {rvalid[1], rvalid[0]}, 32'h0);

    // Vector table: R1 R5 R6 R7 R8 R9 lane and alignment behaviour
    for (int i = 0; i < NVEC; i++) begin
      logic [52:0] v = VEC[i];
      single(int'(v[52]), v[51], v[50:49], v[32+AW-1:32], v[31:0], v[48],
             "R1 R5 R6 R7 R8 R9 vector read data");
    end

    // R2: both masters stream writes to different banks, one per cycle
    begin
      int cycles = 0;
      int both = 0;
      big_endian = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        set_port(0, 1'b1, 2'd2, AW'(32'h080 + 4*i), 32'hA0000000 + i);
        set_port(1, 1'b1, 2'd2, AW'(32'h480 + 4*i), 32'hB0000000 + i);
        #1;
        if (rdy[0] && rdy[1]) both++;
        cycles++;
        model_write(addr[0], 2'd2, wdata[0], 1'b0);
        model_write(addr[1], 2'd2, wdata[1], 1'b0);
        @(posedge clk);
      end
      @(negedge clk);
      req[0] = 1'b0; req[1] = 1'b0;
      check(both == 8, "R2 dual-bank throughput", 32'(both), 32'd8);
      check(cycles == 8, "R2 cycle count", 32'(cycles), 32'd8);
    end
    single(0, 1'b0, 2'd2, AW'(32'h09C), 32'h0, 1'b0, "R2 bank0 stream readback");
    single(1, 1'b0, 2'd2, AW'(32'h49C), 32'h0, 1'b0, "R2 bank1 stream readback");

    // R2 R4: simultaneous reads to different banks
    @(negedge clk);
    set_port(0, 1'b0, 2'd2, AW'(32'h484), 32'h0);
    set_port(1, 1'b0, 2'd2, AW'(32'h084), 32'h0);
    #1;
    check(rdy[0] && rdy[1], "R2 parallel reads accepted", {rdy[1], rdy[0]}, 32'h3);
    @(posedge clk);
    @(negedge clk);
    req[0] = 1'b0; req[1] = 1'b0;
    check(rvalid[0] && rvalid[1], "R4 parallel rvalid", {rvalid[1], rvalid[0]}, 32'h3);
    check(rdata[0] === model_read(AW'(32'h484), 2'd2, 1'b0), "R2 master0 gets bank1 data",
          rdata[0], model_read(AW'(32'h484), 2'd2, 1'b0));
    check(rdata[1] === model_read(AW'(32'h084), 2'd2, 1'b0), "R2 master1 gets bank0 data",
          rdata[1], model_read(AW'(32'h084), 2'd2, 1'b0));

    // R3: contention on bank 0, three writes per master, held until accepted
    begin
      int left [2] = '{3, 3};
      int prev = -1;
      int alt_ok = 1;
      int single_ok = 1;
      int cycles = 0;
      while ((left[0] > 0 || left[1] > 0) && cycles < 20) begin
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
          if (left[m] > 0)
            set_port(m, 1'b1, 2'd2, AW'(32'h100 + 32'h80*m + 4*(3-left[m])),
                     32'hC0DE0000 + 32'h100*m + (3-left[m]));
          else req[m] = 1'b0;
        end
        #1;
        if (left[0] > 0 && left[1] > 0) begin
          if (rdy[0] == rdy[1]) single_ok = 0;
          if (prev >= 0 && rdy[prev]) alt_ok = 0;
        end
        for (int m = 0; m < 2; m++) begin
          if (req[m] && rdy[m]) begin
            model_write(addr[m], 2'd2, wdata[m], 1'b0);
            left[m]--;
            prev = m;
          end
        end
        cycles++;
        @(posedge clk);
      end
      @(negedge clk);
      req[0] = 1'b0; req[1] = 1'b0;
      check(single_ok == 1, "R3 one winner per contended cycle", 32'(single_ok), 32'h1);
      check(alt_ok == 1, "R3 grant alternates", 32'(alt_ok), 32'h1);
      check(cycles == 6, "R3 six cycles for six same-bank writes", 32'(cycles), 32'd6);
    end
    for (int i = 0; i < 3; i++) begin
      single(0, 1'b0, 2'd2, AW'(32'h100 + 4*i), 32'h0, 1'b0, "R3 master0 write landed");
      single(1, 1'b0, 2'd2, AW'(32'h180 + 4*i), 32'h0, 1'b0, "R3 master1 write landed");
    end

    // R5 R9: byte write leaves neighbours, right-justified zero-extended reads
    single(1, 1'b1, 2'd2, AW'(32'h040), 32'h89ABCDEF, 1'b0, "R5 setup");
    single(1, 1'b1, 2'd0, AW'(32'h043), 32'hFFFFFF5A, 1'b0, "R5 byte write");
    single(0, 1'b0, 2'd2, AW'(32'h040), 32'h0, 1'b0, "R5 neighbours kept");
    single(0, 1'b0, 2'd0, AW'(32'h043), 32'h0, 1'b0, "R9 byte zero-extended");
    single(0, 1'b0, 2'd1, AW'(32'h041), 32'h0, 1'b0, "R6 R9 misaligned half read");

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule